// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands over several clock cycles. It uses radix-2 Booth recoding and handles one multiplier bit per cycle. A start strobe captures both operands. The multiplicand is held in its own register. A double-width product register starts out with the multiplier in its lower half, zero in its upper half, and one extra zero bit appended below the least significant bit.

Each cycle the block inspects the two lowest bits of the product register. It then adds the multiplicand to the upper half, subtracts it from the upper half, or leaves the upper half unchanged. After that it shifts the whole register right by one bit arithmetically. Signed operands need no sign pre-correction.

After WIDTH steps, a one-cycle done pulse marks the final product. The product is presented as separate high and low halves. Both halves hold their value until the next accepted start.

Top module: `booth_mult_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, done_o is 0 and both product halves read 0.
- R2: The recoded pair (current bit, previous bit) selects the step operation: 10 subtracts the multiplicand from the upper half, 01 adds it, and 00 and 11 leave the upper half unchanged. As a result, a multiplier of 0110 (4-bit) times 0010 gives 0x0C.
- R3: Every step ends with an arithmetic right shift that replicates the sign, so negative products come out correctly sign-extended across both halves.
- R4: When start is accepted at clock edge k, done_o is high in the cycle that follows edge k+WIDTH, which is exactly WIDTH steps later.
- R5: done_o is high for exactly one cycle per multiplication.
- R6: After done_o, prod_hi_o and prod_lo_o keep their value until the next accepted start, whatever the operand inputs do.
- R7: A start that arrives while a multiplication is in progress is ignored: the operands it carries are not captured, and neither the result nor the completion time changes.
- R8: The most negative multiplicand times the most negative multiplier gives the correct positive product. For WIDTH=4, -8 x -8 gives 0x40.
- R9: For WIDTH=4, 2 x 7 gives 0000_1110, and 2 x (-3) gives 1111_1010.
- R10: prod_hi_o holds bits [2*WIDTH-1:WIDTH] of the signed product, and prod_lo_o holds bits [WIDTH-1:0]. For every pair of WIDTH-bit signed operands, the two halves together equal the full signed product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| prod_hi_o | output | WIDTH | Upper half of the product |
| prod_lo_o | output | WIDTH | Lower half of the product |
| done_o | output | 1 | One-cycle pulse when the product is final |

## Verification
A wrong recode decision or a lost sign bit in a single step corrupts the final product. That error is visible at prod_hi_o/prod_lo_o in the cycle in which done_o rises. An exhaustive sweep of all 4-bit operand pairs therefore exposes any such fault. A miscounted step counter shows up as done_o arriving earlier or later than WIDTH cycles after the start edge. A start that leaks into a running operation shows up as a product computed from the wrong operands.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_op_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic add_en;
        logic sub;
    } addsub_ctl_t;

    // pair = {current bit, previous bit}
    function automatic step_op_e recode_pair(input logic [1:0] pair);
        case (pair)
            2'b10:   return STEP_SUB;
            2'b01:   return STEP_ADD;
            default: return STEP_HOLD;
        endcase
    endfunction

    function automatic addsub_ctl_t op_to_ctl(input step_op_e op);
        addsub_ctl_t c;
        c.add_en = (op != STEP_HOLD);
        c.sub    = (op == STEP_SUB);
        return c;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0]  pair_i,
    output step_op_e    op_o,
    output addsub_ctl_t ctl_o
);
    always_comb begin
        op_o  = recode_pair(pair_i);
        ctl_o = op_to_ctl(op_o);
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] opd_i,
    input  addsub_ctl_t   ctl_i,
    output logic [AW-1:0] res_o
);
    logic [AW-1:0] opd_sel;
    logic          cin;

    always_comb begin
        if (!ctl_i.add_en) begin
            opd_sel = '0;
            cin     = 1'b0;
        end else if (ctl_i.sub) begin
            opd_sel = ~opd_i;
            cin     = 1'b1;
        end else begin
            opd_sel = opd_i;
            cin     = 1'b0;
        end
        res_o = acc_i + opd_sel + {{(AW-1){1'b0}}, cin};
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
    import booth_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    ctl_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign load_o = (state_q == CTL_IDLE) && start_i;
    assign step_o = (state_q == CTL_RUN);
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (start_i) begin
                        state_q <= CTL_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= CTL_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic [WIDTH-1:0] prod_hi_o,
    output logic [WIDTH-1:0] prod_lo_o,
    output logic             done_o
);
    // upper part carries one guard bit so min*min cannot overflow
    localparam int UW = WIDTH + 1;
    localparam int PW = UW + WIDTH + 1;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic             load, step;
    step_op_e         op;
    addsub_ctl_t      ctl;
    logic [UW-1:0]    upper_sum;
    logic [PW-1:0]    pre_shift;

    booth_seq_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .load_o  (load),
        .step_o  (step),
        .done_o  (done_o)
    );

    booth_recode u_recode (
        .pair_i (prod_q[1:0]),
        .op_o   (op),
        .ctl_o  (ctl)
    );

    booth_addsub #(.AW(UW)) u_addsub (
        .acc_i (prod_q[PW-1 -: UW]),
        .opd_i ({mcand_q[WIDTH-1], mcand_q}),
        .ctl_i (ctl),
        .res_o (upper_sum)
    );

    assign pre_shift = {upper_sum, prod_q[WIDTH:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_i;
            prod_q  <= {{UW{1'b0}}, mplier_i, 1'b0};
        end else if (step) begin
            prod_q  <= {pre_shift[PW-1], pre_shift[PW-1:1]};
        end
    end

    assign prod_hi_o = prod_q[2*WIDTH -: WIDTH];
    assign prod_lo_o = prod_q[WIDTH:1];
endmodule

// File: rtl/booth_mult_seq_chk.sv
module booth_mult_seq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done_o,
    input logic [WIDTH-1:0] mcand_q,
    input logic [WIDTH-1:0] prod_hi_o,
    input logic [WIDTH-1:0] prod_lo_o
);
    localparam int CW = $clog2(WIDTH + 1) + 1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done_o && prod_hi_o == '0 && prod_lo_o == '0));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    run_continue_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cnt < CW'(WIDTH - 1)) |=> busy);

    // R4
    run_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cnt == CW'(WIDTH - 1)) |=> (!busy && done_o));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mcand_q));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)));
endmodule

bind booth_mult_seq booth_mult_seq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (step),
    .done_o    (done_o),
    .mcand_q   (mcand_q),
    .prod_hi_o (prod_hi_o),
    .prod_lo_o (prod_lo_o)
);

// File: tb/booth_mult_seq_test.sv
module booth_mult_seq_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] hi, lo;
    logic         done;

    int checks = 0;
    int errors = 0;

    booth_mult_seq #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start(start),
        .mcand_i(a), .mplier_i(b),
        .prod_hi_o(hi), .prod_lo_o(lo), .done_o(done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [2*W-1:0] sx, sy, p;
        sx = {{W{x[W-1]}}, x};
        sy = {{W{y[W-1]}}, y};
        p = sx * sy;
        return p;
    endfunction

    // runs one multiply; optional mid-run start with other operands
    task automatic run_mult(input logic [W-1:0] x, input logic [W-1:0] y,
                            input string req, input bit full, input bit poke);
        int cyc;
        logic [2*W-1:0] exp, got;
        exp = ref_prod(x, y);
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        for (int i = 0; i < 3 * W; i++) begin
            if (poke && i == 1) begin
                a = ~x; b = y + 1'b1; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) break;
        end
        got = {hi, lo};
        check(got == exp, req, int'(got), int'(exp));
        if (full) begin
            // R4
            check(cyc == W, "R4 latency", cyc, W);
            a = ~a; b = ~b;
            @(negedge clk);
            // R5
            check(done == 1'b0, "R5 done pulse width", int'(done), 0);
            repeat (3) @(negedge clk);
            // R6
            check({hi, lo} == exp, "R6 hold after done", int'({hi, lo}), int'(exp));
        end
    endtask

    task automatic test_reset();
        // R1
        check(done == 1'b0 && hi == '0 && lo == '0, "R1 reset state", int'({done, hi, lo}), 0);
    endtask

    task automatic test_examples();
        run_mult(4'd2, 4'd7, "R9 2x7", 1'b1, 1'b0);
        check({hi, lo} == 8'h0E, "R9 2x7 literal", int'({hi, lo}), 8'h0E);
        run_mult(4'd2, 4'hD, "R9 2x-3", 1'b1, 1'b0);
        check({hi, lo} == 8'hFA, "R9 2x-3 literal", int'({hi, lo}), 8'hFA);
    endtask

    task automatic test_recode();
        run_mult(4'd2, 4'b0110, "R2 run of ones", 1'b1, 1'b0);
        check({hi, lo} == 8'h0C, "R2 2x6 literal", int'({hi, lo}), 8'h0C);
        run_mult(4'd5, 4'b0101, "R2 alternating", 1'b0, 1'b0);
        run_mult(4'd3, 4'b1111, "R3 all ones multiplier", 1'b0, 1'b0);
        run_mult(4'hB, 4'd0, "R2 zero multiplier", 1'b0, 1'b0);
    endtask

    task automatic test_min_min();
        run_mult(4'h8, 4'h8, "R8 min x min", 1'b1, 1'b0);
        check({hi, lo} == 8'h40, "R8 min x min literal", int'({hi, lo}), 8'h40);
        run_mult(4'h8, 4'h7, "R8 min x max", 1'b0, 1'b0);
    endtask

    task automatic test_busy_start();
        run_mult(4'd3, 4'd5, "R7 start while busy ignored", 1'b1, 1'b1);
    endtask

    task automatic test_sweep();
        for (int i = 0; i < (1 << W); i++)
            for (int j = 0; j < (1 << W); j++)
                run_mult(W'(i), W'(j), "R10 R3 sweep", 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_examples();
        test_recode();
        test_min_min();
        test_busy_start();
        test_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule